// File: doc/BRIEF.md
# Write Strobe Generator and Port Pin Multiplexer

This block produces the active-low write-control strobes for an external memory bus and routes them onto a general-purpose 8-pin port. Each bus request carries four things: a read/write flag, a byte/word size, byte address bit 0 and the bus width (8 or 16 bits). A small cycle state machine runs every accepted request through three phases. The strobes are decoded from the latched request and from a configuration bit. In split mode the two pins carry separate low-lane and high-lane write strobes. In single mode one pin carries a plain write strobe and the other carries an active-low high-byte-enable.

The same block holds the port's direction, mode and output latch registers and a read-only pin-level register, behind a simple register write/read interface. Each mode bit decides whether a pin shows its special-function signal (a write strobe, or a pass-through alternate signal) or the latch value. Each direction bit decides whether the pin is push-pull or open-drain/input.

Cycle states: `CYC_IDLE` (waiting; a request moves to `CYC_ADDR`), `CYC_ADDR` (address phase, always moves to `CYC_STROBE`), `CYC_STROBE` (write strobe phase, always moves to `CYC_RECOVER`), `CYC_RECOVER` (strobe released, always returns to `CYC_IDLE`).

Top module: `wsp_top`

## Requirements
- R1: After reset the direction register reads FFh, the mode register reads 00h, the output latch reads FFh, the cycle is idle and both strobe signals are high.
- R2: In split mode on a 16-bit bus, a write drives the low-lane strobe (pin 2) low in the strobe phase for a word or for a byte with address bit 0 = 0. It drives the high-lane strobe (pin 5) low for a word or for a byte with address bit 0 = 1.
- R3: In split mode on an 8-bit bus, every write drives both pin 2 and pin 5 low in the strobe phase, whatever address bit 0 and the size are.
- R4: In single mode (cfg_single_wr = 1), pin 2 goes low in the strobe phase of every write. Pin 5 (high-byte-enable) goes low in all three busy phases of a write that is a word or has address bit 0 = 1, and stays high otherwise. The configuration bit is sampled when the request is accepted.
- R5: A request is accepted only in the idle state. The strobe phase is the second cycle after acceptance and lasts exactly one cycle. A cycle takes three clocks before idle returns, and requests during those three clocks are ignored.
- R6: A read request runs the cycle but asserts neither strobe pin in either mode.
- R7: A pin whose mode bit is 1 carries its special-function value: the strobe on pins 2 and 5, and the matching alt_func_in bit on the other pins. A pin whose mode bit is 0 carries its output-latch bit.
- R8: A pin whose direction bit is 0 has pad_oe high and drives its value on pad_out.
- R9: A pin whose direction bit is 1 has pad_oe high only while its value is 0, so a value of 1 leaves the pin released as an input.
- R10: The pin register (address 1FF7h) always reads the live pad_in level, and writes to that address have no effect.
- R11: The direction register is at 1FF3h, the mode register at 1FF1h and the output latch at 1FF5h. Each reads back what was last written, and any other address reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus cycle request, sampled in idle |
| bus_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_word | input | 1 | 1 = word transfer, 0 = byte transfer |
| bus_a0 | input | 1 | Byte address bit 0 |
| bus_16bit | input | 1 | 1 = 16-bit bus cycle, 0 = 8-bit |
| cfg_single_wr | input | 1 | 1 = write strobe plus high-byte-enable, 0 = split lane strobes |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 16 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| pad_in | input | 8 | Live pin levels |
| alt_func_in | input | 8 | Special-function values for the non-strobe pins |
| pad_out | output | 8 | Pin output values |
| pad_oe | output | 8 | Pin output enables, active high |

## Verification
A cycle state stuck or skipped shows on pins 2 and 5 within three clocks. The strobe then lands one cycle early or late, repeats, or never comes. Every clock the bench compares pad_out and pad_oe against its own model, so such a fault fails on the very cycle it differs. Suppose the latched request or the configuration bit is wrong. Then the strobe-phase pattern on the two pins is wrong in that same strobe cycle, or in single mode the high-byte-enable is already wrong in the address phase. A wrong register bit shows on the next cycle's pad_out and pad_oe and on readback.

// File: rtl/wsp_pkg.sv
package wsp_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE    = 2'd0,
        CYC_ADDR    = 2'd1,
        CYC_STROBE  = 2'd2,
        CYC_RECOVER = 2'd3
    } cyc_state_t;

    typedef struct packed {
        logic wr;
        logic word;
        logic a0;
        logic bus16;
        logic single;
    } bus_req_t;

endpackage

// File: rtl/wsp_strobe_fsm.sv
module wsp_strobe_fsm
    import wsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  bus_req_t   req_in,
    output cyc_state_t state_o,
    output logic       lo_n,
    output logic       hi_n
);

    cyc_state_t state_q, state_d;
    bus_req_t   req_q;
    logic       accept;

    assign accept  = (state_q == CYC_IDLE) && req_valid;
    assign state_o = state_q;

    // state register and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CYC_IDLE;
            req_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                req_q <= req_in;
            end
        end
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CYC_IDLE:    state_d = req_valid ? CYC_ADDR : CYC_IDLE;
            CYC_ADDR:    state_d = CYC_STROBE;
            CYC_STROBE:  state_d = CYC_RECOVER;
            CYC_RECOVER: state_d = CYC_IDLE;
            default:     state_d = CYC_IDLE;
        endcase
    end

    // strobe outputs from registered state and request
    logic upper_lane;
    logic lower_lane;
    assign upper_lane = req_q.word | req_q.a0;
    assign lower_lane = req_q.word | ~req_q.a0;

    always_comb begin
        lo_n = 1'b1;
        hi_n = 1'b1;
        unique case (state_q)
            CYC_IDLE: begin
                lo_n = 1'b1;
                hi_n = 1'b1;
            end
            CYC_ADDR, CYC_RECOVER: begin
                if (req_q.single && req_q.wr && upper_lane) begin
                    hi_n = 1'b0;
                end
            end
            CYC_STROBE: begin
                if (req_q.wr) begin
                    if (req_q.single) begin
                        lo_n = 1'b0;
                        hi_n = ~upper_lane;
                    end else if (!req_q.bus16) begin
                        lo_n = 1'b0;
                        hi_n = 1'b0;
                    end else begin
                        lo_n = ~lower_lane;
                        hi_n = ~upper_lane;
                    end
                end
            end
            default: begin
                lo_n = 1'b1;
                hi_n = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/wsp_port_regs.sv
module wsp_port_regs #(
    parameter int unsigned W         = 8,
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DIR_ADDR  = 16'h1FF3,
    parameter int unsigned MODE_ADDR = 16'h1FF1,
    parameter int unsigned DATA_ADDR = 16'h1FF5,
    parameter int unsigned PIN_ADDR  = 16'h1FF7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      mode_q,
    output logic [W-1:0]      data_q
);

    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(DIR_ADDR);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(MODE_ADDR);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);
    localparam logic [ADDR_W-1:0] A_PIN  = ADDR_W'(PIN_ADDR);

    logic hit_dir, hit_mode, hit_data, hit_pin;

    assign hit_dir  = (addr == A_DIR);
    assign hit_mode = (addr == A_MODE);
    assign hit_data = (addr == A_DATA);
    assign hit_pin  = (addr == A_PIN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '1;
            mode_q <= '0;
            data_q <= '1;
        end else if (wr_en) begin
            if (hit_dir)  dir_q  <= wdata;
            if (hit_mode) mode_q <= wdata;
            if (hit_data) data_q <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_dir)  rdata = dir_q;
        if (hit_mode) rdata = mode_q;
        if (hit_data) rdata = data_q;
        if (hit_pin)  rdata = pin_in;
    end

endmodule

// File: rtl/wsp_pad_ctrl.sv
module wsp_pad_ctrl #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] mode,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] latch,
    input  logic [W-1:0] sf,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic val;
        assign val        = mode[i] ? sf[i] : latch[i];
        assign pad_out[i] = val;
        // open-drain or input: only pull low, otherwise release
        assign pad_oe[i]  = dir[i] ? ~val : 1'b1;
    end

endmodule

// File: rtl/wsp_top.sv
module wsp_top
    import wsp_pkg::*;
#(
    parameter int unsigned PIN_W     = 8,
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned LO_BIT    = 2,
    parameter int unsigned HI_BIT    = 5,
    parameter int unsigned DIR_ADDR  = 16'h1FF3,
    parameter int unsigned MODE_ADDR = 16'h1FF1,
    parameter int unsigned DATA_ADDR = 16'h1FF5,
    parameter int unsigned PIN_ADDR  = 16'h1FF7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic              bus_word,
    input  logic              bus_a0,
    input  logic              bus_16bit,
    input  logic              cfg_single_wr,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [PIN_W-1:0]  reg_wdata,
    output logic [PIN_W-1:0]  reg_rdata,
    input  logic [PIN_W-1:0]  pad_in,
    input  logic [PIN_W-1:0]  alt_func_in,
    output logic [PIN_W-1:0]  pad_out,
    output logic [PIN_W-1:0]  pad_oe
);

    bus_req_t   req_bundle;
    cyc_state_t cyc_state;
    logic       strb_lo_n, strb_hi_n;
    logic [PIN_W-1:0] dir_q, mode_q, data_q, sf_vec;

    assign req_bundle = '{wr: bus_wr, word: bus_word, a0: bus_a0,
                          bus16: bus_16bit, single: cfg_single_wr};

    wsp_strobe_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (bus_req),
        .req_in    (req_bundle),
        .state_o   (cyc_state),
        .lo_n      (strb_lo_n),
        .hi_n      (strb_hi_n)
    );

    wsp_port_regs #(
        .W(PIN_W), .ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR),
        .MODE_ADDR(MODE_ADDR), .DATA_ADDR(DATA_ADDR), .PIN_ADDR(PIN_ADDR)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .pin_in (pad_in),
        .dir_q  (dir_q),
        .mode_q (mode_q),
        .data_q (data_q)
    );

    always_comb begin
        sf_vec         = alt_func_in;
        sf_vec[LO_BIT] = strb_lo_n;
        sf_vec[HI_BIT] = strb_hi_n;
    end

    wsp_pad_ctrl #(.W(PIN_W)) u_pads (
        .mode    (mode_q),
        .dir     (dir_q),
        .latch   (data_q),
        .sf      (sf_vec),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

endmodule

// File: rtl/wsp_checker.sv
module wsp_checker
    import wsp_pkg::*;
#(
    parameter int unsigned W        = 8,
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned PIN_ADDR = 16'h1FF7
) (
    input logic              clk,
    input logic              rst_n,
    input cyc_state_t        cyc_state,
    input logic              strb_lo_n,
    input logic              strb_hi_n,
    input logic [W-1:0]      dir_q,
    input logic [W-1:0]      pad_out,
    input logic [W-1:0]      pad_oe,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [W-1:0]      reg_rdata,
    input logic [W-1:0]      pad_in
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_state == CYC_IDLE) |-> (strb_lo_n && strb_hi_n));

    assert_strobe_in_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_lo_n) |-> (cyc_state == CYC_STROBE));

    assert_strobe_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_lo_n) |=> strb_lo_n);

    assert_pushpull_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((~dir_q) & (~pad_oe)) == '0);

    assert_opendrain_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q & pad_oe & pad_out) == '0);

    assert_pin_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(PIN_ADDR)) |-> (reg_rdata == pad_in));

endmodule

bind wsp_top wsp_checker #(.W(PIN_W), .ADDR_W(ADDR_W), .PIN_ADDR(PIN_ADDR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_state (cyc_state),
    .strb_lo_n (strb_lo_n),
    .strb_hi_n (strb_hi_n),
    .dir_q     (dir_q),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .pad_in    (pad_in)
);

// File: tb/tb_wsp_top.sv
`timescale 1ns/1ps
module tb_wsp_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 0, bus_wr = 0, bus_word = 0, bus_a0 = 0, bus_16bit = 0;
    logic        cfg_single_wr = 0;
    logic        reg_we = 0;
    logic [15:0] reg_addr = 16'h0000;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic [7:0]  pad_in = 8'h00;
    logic [7:0]  alt_func_in = 8'h00;
    logic [7:0]  pad_out, pad_oe;

    int checks = 0;
    int errors = 0;
    bit chk_en = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    wsp_top dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_word(bus_word), .bus_a0(bus_a0), .bus_16bit(bus_16bit),
        .cfg_single_wr(cfg_single_wr), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .alt_func_in(alt_func_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // behavioural reference model
    int       m_phase = 0;
    bit       m_wr = 0, m_word = 0, m_a0 = 0, m_b16 = 0, m_single = 0;
    bit [7:0] m_dir = 8'hFF, m_mode = 8'h00, m_data = 8'hFF;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_wr = 0; m_word = 0; m_a0 = 0; m_b16 = 0; m_single = 0;
            m_dir = 8'hFF; m_mode = 8'h00; m_data = 8'hFF;
        end else begin
            if (reg_we) begin
                case (reg_addr)
                    16'h1FF3: m_dir  = reg_wdata;
                    16'h1FF1: m_mode = reg_wdata;
                    16'h1FF5: m_data = reg_wdata;
                    default: ;
                endcase
            end
            if (m_phase == 0) begin
                if (bus_req) begin
                    m_phase = 1; m_wr = bus_wr; m_word = bus_word; m_a0 = bus_a0;
                    m_b16 = bus_16bit; m_single = cfg_single_wr;
                end
            end else begin
                m_phase = (m_phase + 1) % 4;
            end
        end
    end

    function automatic bit [7:0] model_out();
        bit lo_act, hi_act;
        bit [7:0] sf;
        bit [7:0] v;
        lo_act = 0; hi_act = 0;
        if (m_wr) begin
            if (m_single) begin
                lo_act = (m_phase == 2);
                hi_act = (m_phase != 0) && (m_word || m_a0);
            end else if (m_phase == 2) begin
                lo_act = !m_b16 || m_word || !m_a0;
                hi_act = !m_b16 || m_word || m_a0;
            end
        end
        sf = alt_func_in;
        sf[2] = !lo_act;
        sf[5] = !hi_act;
        for (int i = 0; i < 8; i++) v[i] = m_mode[i] ? sf[i] : m_data[i];
        return v;
    endfunction

    function automatic bit [7:0] model_oe(bit [7:0] v);
        bit [7:0] oe;
        for (int i = 0; i < 8; i++) oe[i] = m_dir[i] ? !v[i] : 1'b1;
        return oe;
    endfunction

    task automatic check8(string tag, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    // every-cycle comparison, 1 ns before the rising edge
    always begin
        @(negedge clk);
        #3;
        if (chk_en && !done) begin
            check8("R7", "pad_out per-cycle", pad_out, model_out());
            check8("R9", "pad_oe per-cycle", pad_oe, model_oe(model_out()));
        end
    end

    task automatic reg_write(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic reg_check(string tag, logic [15:0] a, logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #3;
        check8(tag, "register read", reg_rdata, exp);
    endtask

    // one bus cycle; pins 2 and 5 checked in address and strobe phases
    task automatic run_cycle(string tag, bit wr, bit word, bit a0, bit b16, bit single,
                             bit exp_hi_addr, bit exp_lo_stb, bit exp_hi_stb);
        @(negedge clk);
        bus_req = 1; bus_wr = wr; bus_word = word; bus_a0 = a0;
        bus_16bit = b16; cfg_single_wr = single;
        @(negedge clk);
        bus_req = 0; bus_wr = !wr; bus_a0 = !a0; cfg_single_wr = !single;
        #3;
        check8("R5", "pin2 in address phase", {7'd0, pad_out[2]}, 8'd1);
        check8(tag, "pin5 in address phase", {7'd0, pad_out[5]}, {7'd0, exp_hi_addr});
        @(negedge clk);
        #3;
        check8(tag, "pin2 in strobe phase", {7'd0, pad_out[2]}, {7'd0, exp_lo_stb});
        check8(tag, "pin5 in strobe phase", {7'd0, pad_out[5]}, {7'd0, exp_hi_stb});
        @(negedge clk);
        #3;
        check8("R5", "pin2 in recover phase", {7'd0, pad_out[2]}, 8'd1);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n_strobe;
        repeat (3) @(negedge clk);
        #3;
        check8("R1", "pad_out in reset", pad_out, 8'hFF);
        check8("R1", "pad_oe in reset", pad_oe, 8'h00);
        rst_n = 1;
        chk_en = 1;
        reg_check("R1", 16'h1FF3, 8'hFF);
        reg_check("R1", 16'h1FF1, 8'h00);
        reg_check("R1", 16'h1FF5, 8'hFF);

        // R11 register map and readback
        reg_write(16'h1FF5, 8'hA5);
        reg_write(16'h1FF3, 8'h00);
        reg_check("R11", 16'h1FF5, 8'hA5);
        reg_check("R11", 16'h1FF3, 8'h00);
        reg_check("R11", 16'h1FF0, 8'h00);
        #3;
        check8("R7", "latch drives pins", pad_out, 8'hA5);
        check8("R8", "push-pull enables", pad_oe, 8'hFF);

        // R7 special-function path
        alt_func_in = 8'h5A;
        reg_write(16'h1FF1, 8'hFF);
        #3;
        check8("R7", "special-function pins idle", pad_out, 8'h7E);
        reg_write(16'h1FF1, 8'h24);
        reg_check("R11", 16'h1FF1, 8'h24);

        // R2 split 16-bit
        run_cycle("R2", 1, 1, 0, 1, 0, 1, 0, 0);
        run_cycle("R2", 1, 0, 0, 1, 0, 1, 0, 1);
        run_cycle("R2", 1, 0, 1, 1, 0, 1, 1, 0);
        // R3 split 8-bit
        run_cycle("R3", 1, 0, 1, 0, 0, 1, 0, 0);
        run_cycle("R3", 1, 0, 0, 0, 0, 1, 0, 0);
        // R4 single mode
        run_cycle("R4", 1, 1, 0, 1, 1, 0, 0, 0);
        run_cycle("R4", 1, 0, 0, 1, 1, 1, 0, 1);
        run_cycle("R4", 1, 0, 1, 0, 1, 0, 0, 0);
        // R6 reads
        run_cycle("R6", 0, 1, 0, 1, 0, 1, 1, 1);
        run_cycle("R6", 0, 1, 1, 1, 1, 1, 1, 1);

        // R5 requests while busy are ignored
        @(negedge clk);
        bus_req = 1; bus_wr = 1; bus_word = 1; bus_16bit = 1; cfg_single_wr = 0;
        @(negedge clk);
        @(negedge clk);
        bus_req = 0;
        n_strobe = 0;
        for (int k = 0; k < 6; k++) begin
            #3;
            if (pad_out[2] == 1'b0) n_strobe++;
            @(negedge clk);
        end
        check8("R5", "strobe count with busy request", 8'(n_strobe), 8'd1);

        // R9 open-drain / input
        reg_write(16'h1FF1, 8'h00);
        reg_write(16'h1FF5, 8'h0F);
        reg_write(16'h1FF3, 8'hFF);
        #3;
        check8("R9", "open-drain values", pad_out, 8'h0F);
        check8("R9", "open-drain enables", pad_oe, 8'hF0);

        // R10 live pin register, writes ignored
        pad_in = 8'h96;
        reg_check("R10", 16'h1FF7, 8'h96);
        reg_write(16'h1FF7, 8'h00);
        reg_check("R10", 16'h1FF7, 8'h96);
        pad_in = 8'h33;
        reg_check("R10", 16'h1FF7, 8'h33);
        reg_check("R10", 16'h1FF3, 8'hFF);

        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule